// File: doc/BRIEF.md
# Wide-Bus Ethernet FCS Generator/Checker

This block computes the 32-bit Ethernet frame check sequence over a frame delivered eight bytes per clock on a 64-bit bus. Each accepted word advances a 32-bit CRC register through a purely combinational XOR network in a single cycle. Bits are taken least significant first within each byte. The polynomial is 0x04C11DB7, applied in its reflected form 0xEDB88320. The word that closes a frame may carry from one to eight valid bytes, so any frame length is handled without padding.

The same datapath serves both directions. On transmit, the complemented register (`out_fcs`) is the FCS to append after the payload. On receive, the whole frame, including its trailing FCS bytes, is streamed through the register. The frame is then flagged good when the uncomplemented register equals the fixed residue. In the least-significant-bit-first register form that residue is 0xDEBB20E3, which is 0xC704DD7B in normal bit order.

The input side follows valid/ready rules. A word transfers on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is held high at all times: the block never applies back-pressure, so a source may stream one word every cycle.

Top module: `fcs64_engine`

## Requirements
- R1: Reset, or a cycle with `init` high and `in_valid` low, presets the CRC register to 0xFFFFFFFF. After it, `out_fcs` reads 0x00000000 and `out_ok` reads 0.
- R2: For frames whose length is a multiple of 8 bytes, `out_fcs` equals the complement of the bit-serial reflected CRC of the frame. The check string "123456789" gives 0xCBF43926.
- R3: On a word with `in_last` high, `in_bytes` gives the count of valid bytes, with 0 meaning 8. Lane 0 (bits 7:0) is the earliest byte. Lanes at or above the count do not affect the result. `in_bytes` is ignored on words without `in_last`.
- R4: A cycle with `in_valid` low leaves the CRC register unchanged, whatever is on `in_data`, `in_last` and `in_bytes`.
- R5: `out_valid` is high for exactly the cycle after each accepted word with `in_last` high, and is low otherwise. In that cycle `out_fcs` holds the frame's FCS. Byte `out_fcs[7:0]` is the first to transmit.
- R6: After a frame whose last four bytes are its FCS in transmit order, `out_ok` is 1 if the register equals the good-frame residue and 0 otherwise. `out_ok` changes only together with `out_valid`, or on an init.
- R7: `out_ok` keeps its value through idle cycles and non-final words until the next `init` or the next final word.
- R8: A word accepted with `init` high is folded into a freshly preset register. A new frame can therefore start on its first data word, discarding any unfinished frame.
- R9: `in_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| init | input | 1 | Preset the CRC register for a new frame |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted (always high) |
| in_data | input | 64 | Eight frame bytes, lane 0 earliest |
| in_last | input | 1 | Word closes the frame |
| in_bytes | input | 3 | Valid bytes in the closing word, 0 means 8 |
| out_valid | output | 1 | One-cycle strobe after the closing word |
| out_fcs | output | 32 | Complemented CRC register, low byte sent first |
| out_ok | output | 1 | Received frame matched the good-frame residue |

## Verification
The assertions assume that `in_bytes` matters only when `in_last` accompanies `in_valid`. They also assume that a frame's first word is preceded by, or carries, an `init`. The stimulus meets these by construction: every frame either opens with `init` on its first word or follows a standalone init cycle. Idle cycles are inserted between words with inverted data and a spurious `in_last`, so the hold properties face hostile values. Unused lanes of each closing word are filled with non-zero garbage, and `in_bytes` on non-final words is set to an arbitrary count, so the length selection is exercised against wrong inputs.

// File: rtl/fcs64_pkg.sv
package fcs64_pkg;
  localparam logic [31:0] POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] PRESET    = 32'hFFFFFFFF;
  // Good-frame remainder in the LSB-first register form (0xC704DD7B bit-reversed)
  localparam logic [31:0] RESIDUE   = 32'hDEBB20E3;

  // One byte through the reflected register, bit 0 first
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs64_byte_chain.sv
module fcs64_byte_chain #(
  parameter int LANES = 8
) (
  input  logic [31:0]           seed,
  input  logic [8*LANES-1:0]    data,
  output logic [LANES:0][31:0]  states
);
  // states[k] is the register after the first k lanes
  assign states[0] = seed;
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign states[k+1] = fcs64_pkg::crc_byte(states[k], data[8*k +: 8]);
  end
endmodule

// File: rtl/fcs64_len_select.sv
module fcs64_len_select #(
  parameter int LANES = 8,
  localparam int CNT_W = $clog2(LANES)
) (
  input  logic [LANES:0][31:0]  states,
  input  logic                  last,
  input  logic [CNT_W-1:0]      count,
  output logic [31:0]           nxt
);
  logic [CNT_W:0] sel;
  always_comb begin
    sel = (CNT_W+1)'(LANES);
    if (last && count != '0) sel = {1'b0, count};
  end
  assign nxt = states[sel];
endmodule

// File: rtl/fcs64_engine.sv
module fcs64_engine #(
  parameter int LANES = 8,
  localparam int DW    = 8*LANES,
  localparam int CNT_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  input  logic [CNT_W-1:0] in_bytes,
  output logic             out_valid,
  output logic [31:0]      out_fcs,
  output logic             out_ok
);
  import fcs64_pkg::*;

  logic [31:0]           crc_q;
  logic [31:0]           seed;
  logic [31:0]           nxt;
  logic [LANES:0][31:0]  states;
  logic                  accept;
  logic                  vld_q;
  logic                  ok_q;

  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready;
  assign seed     = init ? PRESET : crc_q;

  fcs64_byte_chain #(.LANES(LANES)) u_chain (
    .seed   (seed),
    .data   (in_data),
    .states (states)
  );

  fcs64_len_select #(.LANES(LANES)) u_sel (
    .states (states),
    .last   (in_last),
    .count  (in_bytes),
    .nxt    (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= PRESET;
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      vld_q <= accept && in_last;
      if (accept)    crc_q <= nxt;
      else if (init) crc_q <= PRESET;
      if (accept && in_last) ok_q <= (nxt == RESIDUE);
      else if (init)         ok_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_fcs   = ~crc_q;
  assign out_ok    = ok_q;

  // R1
  a_r1_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (init && !in_valid) |=> (out_fcs == 32'h0 && !out_ok));
  // R4
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !init) |=> $stable(out_fcs));
  // R5
  a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> out_valid);
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !out_valid);
  // R6
  a_r6_ok_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ok) |-> out_valid);
  // R7
  a_r7_ok_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !(in_valid && in_last)) |=> $stable(out_ok));
  // R9
  a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
endmodule

// File: tb/sim_fcs64_engine.sv
module sim_fcs64_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [63:0] in_data = '0;
  logic [2:0]  in_bytes = '0;
  logic        in_ready, out_valid, out_ok;
  logic [31:0] out_fcs;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  byte unsigned fb [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  fcs64_engine u0 (
    .clk(clk), .rst_n(rst_n), .init(init), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_fcs(out_fcs), .out_ok(out_ok)
  );

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-serial reflected CRC register over fb[0..len-1]
  function automatic logic [31:0] ref_reg(int len);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int n = 0; n < len; n++)
      for (int i = 0; i < 8; i++) begin
        logic f = r[0] ^ fb[n][i];
        r = r >> 1;
        if (f) r = r ^ 32'hEDB88320;
      end
    return r;
  endfunction

  // Returns at the negedge where out_valid should be high
  task automatic drive_frame(int len, bit gaps, bit init_first);
    int beats = (len + 7) / 8;
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      init     = (b == 0) && init_first;
      in_valid = 1'b1;
      for (int l = 0; l < 8; l++)
        in_data[8*l +: 8] = (b*8+l < len) ? fb[b*8+l] : (8'hA5 ^ 8'(l+1));
      in_last  = (b == beats-1);
      in_bytes = (b == beats-1) ? 3'(len % 8) : 3'd5;
      if (gaps && b != beats-1) begin
        @(negedge clk);
        init = 1'b0; in_valid = 1'b0; in_data = ~in_data; in_last = 1'b1; in_bytes = 3'd1;
      end
    end
    @(negedge clk);
    init = 1'b0; in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic fill(int len, int salt);
    for (int i = 0; i < len; i++) fb[i] = 8'((i*37 + salt*11 + 3) & 8'hFF);
  endtask

  initial begin
    logic [31:0] f;
    repeat (3) @(negedge clk);
    check_eq("R1 reset out_fcs", out_fcs, 32'h0);
    check_eq("R1 reset out_ok", {31'b0, out_ok}, 32'h0);
    check_eq("R5 reset out_valid", {31'b0, out_valid}, 32'h0);
    check_eq("R9 ready in reset", {31'b0, in_ready}, 32'h1);
    rst_n = 1'b1;

    // R2: check string, partial last word
    for (int i = 0; i < 9; i++) fb[i] = 8'(8'h31 + i);
    drive_frame(9, 0, 1);
    check_eq("R2 check string", out_fcs, 32'hCBF43926);
    check_eq("R5 strobe", {31'b0, out_valid}, 32'h1);
    @(negedge clk);
    check_eq("R5 strobe one cycle", {31'b0, out_valid}, 32'h0);
    check_eq("R9 ready", {31'b0, in_ready}, 32'h1);

    // R1: standalone init then frame without init on its first word
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    check_eq("R1 preset after init", out_fcs, 32'h0);
    fill(20, 7);
    drive_frame(20, 0, 0);
    check_eq("R1 frame after standalone init", out_fcs, ~ref_reg(20));

    // R2/R3/R4: length sweep, gaps on odd lengths
    for (int len = 1; len <= 48; len++) begin
      fill(len, len);
      drive_frame(len, len % 2 == 1, 1);
      if (len % 8 == 0) check_eq("R2 full-word frame", out_fcs, ~ref_reg(len));
      else              check_eq("R3 partial last word", out_fcs, ~ref_reg(len));
      if (len % 2 == 1) check_eq("R4 gapped frame strobe", {31'b0, out_valid}, 32'h1);
    end

    // R8: abandoned frame, then a new frame with init on its first word
    @(negedge clk);
    in_valid = 1'b1; in_data = 64'h0123456789ABCDEF; in_last = 1'b0;
    fill(13, 99);
    drive_frame(13, 0, 1);
    check_eq("R8 restart with init on data", out_fcs, ~ref_reg(13));

    // R6/R7: good frames, hold, init clear, corrupted frames
    for (int len = 1; len <= 40; len++) begin
      fill(len, len + 50);
      f = ~ref_reg(len);
      for (int k = 0; k < 4; k++) fb[len+k] = f[8*k +: 8];
      drive_frame(len + 4, len % 3 == 0, 1);
      check_eq("R6 good frame flagged", {31'b0, out_ok}, 32'h1);
      in_valid = 1'b1; in_last = 1'b0; in_data = 64'hDEADBEEF00C0FFEE;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check_eq("R7 flag held", {31'b0, out_ok}, 32'h1);
      if (len % 10 == 0) begin
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        check_eq("R7 flag cleared by init", {31'b0, out_ok}, 32'h0);
      end
      fb[len/2] = fb[len/2] ^ 8'h10;
      drive_frame(len + 4, 0, 1);
      check_eq("R6 corrupted frame rejected", {31'b0, out_ok}, 32'h0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule